// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Transmitter

This block turns a parallel pair of 24-bit two's-complement samples (left and right) into a serial stereo stream. The stream has a bit clock, a word clock and one data line. Each sample period is 64 bit clocks long and holds two 32-bit slots, left first. A 2-bit format field picks LSB-justified, MSB-justified or I2S-style placement of the sample inside its slot. Data always leaves MSB first and changes only when the bit clock falls.

A 3-bit mode field picks the clock role. In the master codes the block divides its core clock down to a 64fs bit clock and drives both serial clocks itself. The supported core-clock ratios are 128, 256, 384, 512 and 768 times the sample rate. In the slave code it takes both serial clocks from outside, samples them with the core clock, and leaves its own clock outputs low. Software writes a new pair through a load strobe at any time. The block moves that pair into the serializer only at a frame start, so a frame never mixes two pairs.

Mode and format are captured while power-down is high and take effect when it goes low. Power-down also resets the dividers and holds every output low.

Top module: `audioSerialTx`

## Requirements
- R1: With format code 2 (MSB-justified), slot position p carries sample bit 23-p for p = 0..23 and 0 for p = 24..31. Position 0 is the first bit clock after the word-clock edge.
- R2: With format code 0 (LSB-justified), positions 0..7 of a slot carry 0 and position p = 8..31 carries sample bit 31-p.
- R3: With format code 3 (I2S), position 0 carries 0, position p = 1..24 carries sample bit 24-p, and positions 25..31 carry 0. The word clock is low during the left slot.
- R4: A frame is 64 bit clocks: the left slot (32 bit clocks) and then the right slot. With format codes 0, 1 and 2 the word clock is high during the left slot.
- R5: In master modes, serData and wordClk change only on the core-clock edge at which bitClk falls.
- R6: Mode codes 0, 1, 2, 3 and 5 are master modes with bitClk periods of 4, 6, 8, 12 and 2 core-clock cycles (ratio/64). The bit clock is high for the first half of each period.
- R7: Format code 1 is reserved and holds serData low, while the clocks run normally.
- R8: Mode code 4 is slave. bitClk and wordClk stay low. On each falling edge of slvBitClk, a change of slvWordClk starts a slot at position 0, and serData follows within 4 core cycles. The external half period must be at least 4 core cycles.
- R9: While powerDown is high, bitClk, wordClk and serData are low. After release the divider starts from zero, so in mode 0 bitClk first rises on the second core-clock edge.
- R10: A pair loaded in mid-frame is not sent in the current frame; it is sent from the next frame start.
- R11: Changes of modeSel or fmtSel while powerDown is low have no effect. The values captured at the power-down release stay in force.
- R12: Mode codes 6 and 7 keep all three outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (master clock in master modes) |
| powerDown | input | 1 | Synchronous power-down, active high |
| modeSel | input | 3 | Clock role and ratio code |
| fmtSel | input | 2 | Slot framing code |
| loadStrobe | input | 1 | Writes leftIn/rightIn into the pending pair |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| slvBitClk | input | 1 | External bit clock in slave mode |
| slvWordClk | input | 1 | External word clock in slave mode |
| bitClk | output | 1 | Bit clock in master modes |
| wordClk | output | 1 | Word clock in master modes |
| serData | output | 1 | Serial data, MSB first |

## Verification
In master modes, serData and wordClk are registered on the same core edge that drops bitClk. Each bit is therefore valid one half period before the next rise of bitClk. The bench samples the outputs on the falling core edge and reads each bit at the next bitClk rise. The bit at the first rise after release is ignored, because no fall has occurred yet. A pair loaded before release appears in frame 0. A pair loaded in mid-frame is expected one full frame later. In slave mode the synchronizer and the edge detector put serData up to three core cycles behind the external fall. The bench therefore reads each bit just before the next external fall, seven cycles into the high phase.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
  localparam int SLOT_BITS = 32;
  localparam int POS_W = $clog2(SLOT_BITS);
  localparam int FRAME_W = POS_W + 1;

  typedef enum logic [1:0] {
    FMT_LSB  = 2'd0,
    FMT_RSVD = 2'd1,
    FMT_MSB  = 2'd2,
    FMT_I2S  = 2'd3
  } fmt_e;

  // strobes from control to datapath, one set per core cycle
  typedef struct packed {
    logic             advance;
    logic             frameStart;
    logic             chan;
    logic [POS_W-1:0] pos;
    fmt_e             fmt;
  } strobe_t;
endpackage

// File: rtl/audtx_ctrl.sv
module audtx_ctrl
  import audtx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       powerDown,
  input  logic [2:0] modeSel,
  input  logic [1:0] fmtSel,
  input  logic       slvBitClk,
  input  logic       slvWordClk,
  output strobe_t    strb,
  output logic       bitClk,
  output logic       wordClk
);
  localparam int DIV_W = 3;

  logic [2:0]             modeReg;
  fmt_e                   fmtReg;
  logic [DIV_W-1:0]       divCnt;
  logic [DIV_W-1:0]       halfDiv;
  logic                   bclkR, wclkR;
  logic [SYNC_STAGES-1:0] bSync, wSync;
  logic                   bLast, wLast, started;
  logic [FRAME_W-1:0]     cnt, nextCnt;
  logic                   isMaster, isSlave, isI2s;
  logic                   bNow, wNow, masterFall, slaveFall, wEdge, wChan, advance;

  // ratio table: half period of the bit clock in core cycles
  always_comb begin
    unique case (modeReg)
      3'd0:    halfDiv = 3'd2;
      3'd1:    halfDiv = 3'd3;
      3'd2:    halfDiv = 3'd4;
      3'd3:    halfDiv = 3'd6;
      default: halfDiv = 3'd1;
    endcase
  end

  assign isMaster = (modeReg <= 3'd3) || (modeReg == 3'd5);
  assign isSlave  = (modeReg == 3'd4);
  assign isI2s    = (fmtReg == FMT_I2S);

  assign bNow       = bSync[SYNC_STAGES-1];
  assign wNow       = wSync[SYNC_STAGES-1];
  assign masterFall = isMaster && bclkR && (divCnt == halfDiv - 3'd1);
  assign slaveFall  = isSlave && bLast && !bNow;
  assign wEdge      = (wNow != wLast);
  assign wChan      = isI2s ? wNow : ~wNow;
  assign advance    = masterFall || (slaveFall && (started || wEdge));

  always_comb begin
    nextCnt = cnt + 1'b1;
    if (isSlave && wEdge) nextCnt = {wChan, {POS_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (powerDown) begin
      modeReg <= modeSel;
      fmtReg  <= fmt_e'(fmtSel);
      divCnt  <= '0;
      bclkR   <= 1'b0;
      wclkR   <= 1'b0;
      cnt     <= '1;
      started <= 1'b0;
      bLast   <= 1'b0;
      wLast   <= 1'b0;
      bSync   <= '0;
      wSync   <= '0;
    end else begin
      bSync <= {bSync[SYNC_STAGES-2:0], slvBitClk};
      wSync <= {wSync[SYNC_STAGES-2:0], slvWordClk};
      bLast <= bNow;
      if (isMaster) begin
        if (divCnt == halfDiv - 3'd1) begin
          divCnt <= '0;
          bclkR  <= ~bclkR;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      if (slaveFall) begin
        wLast <= wNow;
        if (wEdge) started <= 1'b1;
      end
      if (advance) begin
        cnt <= nextCnt;
        if (isMaster) wclkR <= isI2s ? nextCnt[FRAME_W-1] : ~nextCnt[FRAME_W-1];
      end
    end
  end

  assign strb.advance    = advance;
  assign strb.frameStart = advance && (nextCnt == '0);
  assign strb.chan       = nextCnt[FRAME_W-1];
  assign strb.pos        = nextCnt[POS_W-1:0];
  assign strb.fmt        = fmtReg;
  assign bitClk          = bclkR;
  assign wordClk         = wclkR;
endmodule

// File: rtl/audtx_datapath.sv
module audtx_datapath
  import audtx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                powerDown,
  input  logic                loadStrobe,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  strobe_t             strb,
  output logic                serData
);
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam int PAD   = SLOT_BITS - SAMPLE_W;

  logic [SAMPLE_W-1:0] pendL, pendR, actL, actR, src;
  logic                bitNow;
  int                  p;

  // pending pair accepts writes at any time, also during power-down
  always_ff @(posedge clk) begin
    if (loadStrobe) begin
      pendL <= leftIn;
      pendR <= rightIn;
    end
  end

  always_comb begin
    if (strb.frameStart) src = strb.chan ? pendR : pendL;
    else                 src = strb.chan ? actR : actL;
    p      = int'(strb.pos);
    bitNow = 1'b0;
    unique case (strb.fmt)
      FMT_MSB: if (p < SAMPLE_W)             bitNow = src[IDX_W'(SAMPLE_W - 1 - p)];
      FMT_LSB: if (p >= PAD)                 bitNow = src[IDX_W'(SLOT_BITS - 1 - p)];
      FMT_I2S: if (p >= 1 && p <= SAMPLE_W)  bitNow = src[IDX_W'(SAMPLE_W - p)];
      default:                               bitNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (powerDown) begin
      serData <= 1'b0;
    end else if (strb.advance) begin
      if (strb.frameStart) begin
        actL <= pendL;
        actR <= pendR;
      end
      serData <= bitNow;
    end
  end
endmodule

// File: rtl/audioSerialTx.sv
module audioSerialTx
  import audtx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                powerDown,
  input  logic [2:0]          modeSel,
  input  logic [1:0]          fmtSel,
  input  logic                loadStrobe,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                slvBitClk,
  input  logic                slvWordClk,
  output logic                bitClk,
  output logic                wordClk,
  output logic                serData
);
  strobe_t strb;

  audtx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .powerDown(powerDown), .modeSel(modeSel), .fmtSel(fmtSel),
    .slvBitClk(slvBitClk), .slvWordClk(slvWordClk),
    .strb(strb), .bitClk(bitClk), .wordClk(wordClk)
  );

  audtx_datapath #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk(clk), .powerDown(powerDown), .loadStrobe(loadStrobe),
    .leftIn(leftIn), .rightIn(rightIn), .strb(strb), .serData(serData)
  );
endmodule

// File: rtl/audtx_checker.sv
module audtx_checker (
  input logic       clk,
  input logic       powerDown,
  input logic [2:0] modeSel,
  input logic [1:0] fmtSel,
  input logic       bitClk,
  input logic       wordClk,
  input logic       serData
);
  logic [2:0] mMode;
  logic [1:0] mFmt;
  logic [3:0] cyc, expHalf;
  logic       bPrev, mMaster;

  always_ff @(posedge clk) begin
    if (powerDown) begin
      mMode <= modeSel;
      mFmt  <= fmtSel;
      cyc   <= '0;
      bPrev <= 1'b0;
    end else begin
      bPrev <= bitClk;
      cyc   <= (bitClk != bPrev) ? 4'd1 : cyc + 4'd1;
    end
  end

  assign mMaster = (mMode <= 3'd3) || (mMode == 3'd5);
  always_comb begin
    case (mMode)
      3'd0:    expHalf = 4'd2;
      3'd1:    expHalf = 4'd3;
      3'd2:    expHalf = 4'd4;
      3'd3:    expHalf = 4'd6;
      default: expHalf = 4'd1;
    endcase
  end

  a_r9_pd_quiet: assert property (@(posedge clk)
    powerDown |=> (!bitClk && !wordClk && !serData));

  a_r5_data_on_fall: assert property (@(posedge clk) disable iff (powerDown)
    (mMaster && !$stable(serData)) |-> $fell(bitClk));

  a_r5_wclk_on_fall: assert property (@(posedge clk) disable iff (powerDown)
    (mMaster && !$stable(wordClk)) |-> $fell(bitClk));

  a_r6_half_period: assert property (@(posedge clk) disable iff (powerDown)
    (mMaster && (bitClk != bPrev)) |-> (cyc == expHalf));

  a_r7_reserved_low: assert property (@(posedge clk) disable iff (powerDown)
    (mFmt == 2'd1) |-> !serData);

  a_r8_slave_clocks_low: assert property (@(posedge clk) disable iff (powerDown)
    (mMode == 3'd4) |-> (!bitClk && !wordClk));

  a_r12_idle_low: assert property (@(posedge clk) disable iff (powerDown)
    (mMode >= 3'd6) |-> (!bitClk && !wordClk && !serData));
endmodule

bind audioSerialTx audtx_checker chk (.*);

// File: tb/tb_audioSerialTx.sv
module tb_audioSerialTx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        powerDown = 1'b1, loadStrobe = 1'b0;
  logic [2:0]  modeSel = 3'd0;
  logic [1:0]  fmtSel = 2'd2;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic        slvBitClk = 1'b1, slvWordClk = 1'b0;
  logic        bitClk, wordClk, serData;

  audioSerialTx dut (.*);

  int checks = 0, errors = 0;
  int idx, frames, cyc, riseCyc, period, edgeViol, anyHigh, dataHigh;
  logic prevB, prevD, prevW;
  logic bits[64], wcl[64], lastBits[64], lastW[64];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic expBit(int fmt, int pos, logic [23:0] l, logic [23:0] r);
    int p = pos % 32;
    logic [23:0] s = (pos >= 32) ? r : l;
    case (fmt)
      2: return (p < 24) ? s[23-p] : 1'b0;
      0: return (p >= 8) ? s[31-p] : 1'b0;
      3: return (p >= 1 && p <= 24) ? s[24-p] : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic expWclk(int fmt, int pos);
    return (fmt == 3) ? (pos >= 32) : (pos < 32);
  endfunction

  function automatic int expPeriod(int mode);
    case (mode)
      0: return 4; 1: return 6; 2: return 8; 3: return 12; default: return 2;
    endcase
  endfunction

  function automatic string reqOf(int fmt);
    case (fmt)
      0: return "R2"; 3: return "R3"; 1: return "R7"; default: return "R1";
    endcase
  endfunction

  // output monitor on the falling core edge
  always @(negedge clk) begin
    if (powerDown) begin
      idx = -1; frames = 0; cyc = 0; riseCyc = 0;
      prevB = 0; prevD = 0; prevW = 0;
    end else begin
      cyc++;
      if (bitClk || wordClk || serData) anyHigh++;
      if (serData) dataHigh++;
      if ((serData != prevD || wordClk != prevW) && !(prevB && !bitClk)) edgeViol++;
      if (bitClk && !prevB) begin
        period = cyc - riseCyc;
        riseCyc = cyc;
        if (idx < 0) idx = 0;
        else begin
          bits[idx] = serData;
          wcl[idx] = wordClk;
          idx++;
          if (idx == 64) begin
            lastBits = bits;
            lastW = wcl;
            frames++;
            idx = 0;
          end
        end
      end
      prevB = bitClk; prevD = serData; prevW = wordClk;
    end
  end

  task automatic waitFrames(int n);
    while (frames < n) @(negedge clk);
  endtask

  task automatic loadPair(logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    leftIn = l; rightIn = r; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic startMaster(int mode, int fmt, logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    powerDown = 1'b1; modeSel = 3'(mode); fmtSel = 2'(fmt);
    loadPair(l, r);
    repeat (3) @(negedge clk);
    edgeViol = 0; anyHigh = 0; dataHigh = 0;
    powerDown = 1'b0;
  endtask

  task automatic checkFrame(int fmt, logic [23:0] l, logic [23:0] r, string req);
    int bErr = 0, wErr = 0;
    for (int i = 0; i < 64; i++) begin
      if (lastBits[i] !== expBit(fmt, i, l, r)) bErr++;
      if (lastW[i] !== expWclk(fmt, i)) wErr++;
    end
    check(bErr == 0, req, "slot bit mismatches in frame", bErr, 0);
    check(wErr == 0, "R4", "word clock mismatches in frame", wErr, 0);
  endtask

  task automatic runMaster(int mode, int fmt, logic [23:0] l, logic [23:0] r);
    startMaster(mode, fmt, l, r);
    waitFrames(2);
    check(period == expPeriod(mode), "R6", "bit clock period", period, expPeriod(mode));
    checkFrame(fmt, l, r, reqOf(fmt));
    check(edgeViol == 0, "R5", "output changes away from bit clock fall", edgeViol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int modes[5] = '{0, 1, 2, 3, 5};
    int fmts[3] = '{0, 2, 3};
    void'($urandom(32'd4127));

    // R9: outputs quiet during power-down, divider restarts at release
    repeat (4) @(negedge clk);
    check(!bitClk && !wordClk && !serData, "R9", "outputs during power-down",
          {bitClk, wordClk, serData}, 0);
    startMaster(0, 2, 24'hA5C3F1, 24'h123456);
    @(negedge clk);
    check(bitClk == 1'b0, "R9", "bitClk one edge after release", bitClk, 0);
    @(negedge clk);
    check(bitClk == 1'b1, "R9", "bitClk two edges after release", bitClk, 1);

    // directed frames per format; R1 MSB, R2 LSB, R3 I2S, R4 framing
    runMaster(0, 2, 24'hA5C3F1, 24'h123456);
    runMaster(2, 0, 24'h800001, 24'h7FFFFE);
    runMaster(5, 3, 24'hF0F00F, 24'h0C0FFE);

    // random modes, formats and samples
    for (int k = 0; k < 4; k++) begin
      runMaster(modes[$urandom_range(4, 0)], fmts[$urandom_range(2, 0)],
                24'($urandom), 24'($urandom));
    end

    // R7: reserved format keeps data low while clocks run
    startMaster(1, 1, 24'hFFFFFF, 24'hFFFFFF);
    waitFrames(2);
    check(dataHigh == 0, "R7", "serData high cycles with reserved format", dataHigh, 0);
    check(period == 6, "R7", "clock period with reserved format", period, 6);

    // R10: mid-frame load waits for the next frame start
    startMaster(0, 2, 24'h111111, 24'h222222);
    waitFrames(1);
    while (idx != 10) @(negedge clk);
    loadPair(24'hABCDEF, 24'h654321);
    waitFrames(2);
    checkFrame(2, 24'h111111, 24'h222222, "R10");
    waitFrames(3);
    checkFrame(2, 24'hABCDEF, 24'h654321, "R10");

    // R11: select changes while running are ignored
    startMaster(1, 3, 24'h5A5A5A, 24'hC3C3C3);
    waitFrames(1);
    modeSel = 3'd0; fmtSel = 2'd2;
    waitFrames(3);
    check(period == 6, "R11", "period after running mode change", period, 6);
    checkFrame(3, 24'h5A5A5A, 24'hC3C3C3, "R11");

    // R12: unused mode codes stay quiet
    startMaster(6, 2, 24'hFFFFFF, 24'hFFFFFF);
    repeat (300) @(negedge clk);
    check(anyHigh == 0, "R12", "high output cycles in mode 6", anyHigh, 0);

    // R8: slave mode with external clocks, MSB-justified
    begin
      logic [23:0] sl = 24'($urandom), sr = 24'($urandom);
      int dErr = 0, cErr = 0;
      @(negedge clk);
      powerDown = 1'b1; modeSel = 3'd4; fmtSel = 2'd2;
      slvBitClk = 1'b1; slvWordClk = 1'b0;
      loadPair(sl, sr);
      repeat (3) @(negedge clk);
      powerDown = 1'b0;
      repeat (8) @(negedge clk);
      for (int f = 0; f < 2; f++) begin
        for (int pos = 0; pos < 64; pos++) begin
          slvBitClk = 1'b0;
          slvWordClk = (pos < 32);
          repeat (8) @(negedge clk);
          slvBitClk = 1'b1;
          repeat (7) @(negedge clk);
          if (serData !== expBit(2, pos, sl, sr)) dErr++;
          if (bitClk || wordClk) cErr++;
          @(negedge clk);
        end
      end
      check(dErr == 0, "R8", "slave serial bit mismatches", dErr, 0);
      check(cErr == 0, "R8", "clock outputs high in slave mode", cErr, 0);
    end

    finishRun();
  end
endmodule